// File: doc/BRIEF.md
# Four-Phase Shared Memory Arbiter with CPU Wait Generation

This block lets an 8-bit CPU and a video fetch engine share one memory port. A free-running two-bit phase counter steps through four phases, named G1 to G4, one per CPU clock. Only in G1 does the block release the CPU's active-low wait line. This forces every CPU memory or I/O transfer to line up with that one phase out of four. The CPU owns the address multiplexer in G1 and G2. In G3 and G4 the video side reads two consecutive bytes.

CPU read data passes through a holding stage. The stage is transparent while the wait line is released and frozen in every other phase. A CPU read that completes in G2 therefore returns the byte the memory delivered in G1.

CPU write data and the write strobe are cut off from the memory during the two video phases. The video side receives each fetched byte one clock after its read phase, with a valid strobe and a flag that marks the second byte of the pair.

The memory sits outside the block. It is a single port that returns read data combinationally from the address it is given and commits a write at the clock edge.

Top module: `fourphase_bus_arbiter`

## Requirements
- R1: The phase counter advances G1, G2, G3, G4 on successive clocks and returns to G1 after G4. A synchronous reset forces G1, and G1 is held while reset stays high.
- R2: `waitN` is 1 in phase G1 and 0 in G2, G3 and G4.
- R3: In G1 and G2, `memAddr` equals `cpuAddr`.
- R4: In G3, `memAddr` equals `vidAddr`. In G4, it equals `vidAddr` plus one, taken modulo 2^ADDR_W, so all-ones wraps to zero.
- R5: `memWe` is 1 only in G1 or G2, and only when `cpuMreq` and `cpuWr` are both 1 (both active high). `memWdata` carries `cpuWdata` in G1 and G2 and is all zeros in G3 and G4.
- R6: In G1, `cpuRdata` follows `memRdata`. In G2, G3 and G4, it holds the `memRdata` value present at the end of G1.
- R7: `vidValid` is 1 in G4 and in the following G1, and 0 in every other phase. In G4, `vidData` is the byte read in G3 and `vidSecond` is 0. In G1, `vidData` is the byte read in G4 and `vidSecond` is 1.
- R8: While reset is high, `vidValid` is 0 and `waitN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuAddr | input | ADDR_W | CPU address bus |
| cpuWdata | input | DATA_W | CPU write data |
| cpuMreq | input | 1 | CPU memory request, active high |
| cpuWr | input | 1 | CPU write strobe, active high |
| cpuRdata | output | DATA_W | Read data returned to the CPU through the holding stage |
| waitN | output | 1 | Active-low wait to the CPU, released in G1 only |
| vidAddr | input | ADDR_W | Base address of the video byte pair |
| vidData | output | DATA_W | Fetched video byte |
| vidValid | output | 1 | One-clock strobe marking `vidData` valid |
| vidSecond | output | 1 | Marks the byte read from `vidAddr` plus one |
| memAddr | output | ADDR_W | Memory address after multiplexing |
| memWdata | output | DATA_W | Memory write data, zero in the video phases |
| memWe | output | 1 | Memory write enable |
| memRdata | input | DATA_W | Combinational memory read data |

## Verification
The assertions assume that reset is high from time zero until the first edge, so the phase is known before any property is enabled. They also assume the memory returns read data combinationally from the address it is given. The stimulus follows both rules: reset is held from the start, and the bench's memory model answers `memRdata` directly from its array.

The bench changes every input only on the falling edge, so the data sampled at the end of G1 and at the video read phases is settled. It uses a different CPU address in each phase, which makes a stale or early capture in the holding stage visible. It also includes one group whose video address is all ones, which exercises the wrap of the second video byte.

// File: rtl/fpba_pkg.sv
package fpba_pkg;

  typedef enum logic [1:0] {
    PH_G1 = 2'd0,
    PH_G2 = 2'd1,
    PH_G3 = 2'd2,
    PH_G4 = 2'd3
  } phase_e;

  // Strobes sent from the sequencer to the datapath
  typedef struct packed {
    logic cpuSel;     // CPU owns the memory port (G1, G2)
    logic latchOpen;  // read holding stage transparent (G1)
    logic vidRd;      // video byte read this cycle (G3, G4)
    logic vidHi;      // second video byte (G4)
  } strobe_t;

endpackage

// File: rtl/fpba_ctrl.sv
module fpba_ctrl
  import fpba_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output strobe_t strb,
  output logic    waitN
);

  phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_G1;
    else     phase <= phase_e'(2'(phase + 2'd1));
  end

  always_comb begin
    strb.cpuSel    = (phase == PH_G1) || (phase == PH_G2);
    strb.latchOpen = (phase == PH_G1);
    strb.vidRd     = (phase == PH_G3) || (phase == PH_G4);
    strb.vidHi     = (phase == PH_G4);
  end

  assign waitN = (phase == PH_G1);

  // R1: the last phase is always followed by the first
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_G4) |=> (phase == PH_G1));

  // R2: after each release, wait stays low for exactly three clocks
  assert_wait_cadence_R2: assert property (@(posedge clk) disable iff (rst)
    waitN |=> !waitN ##1 !waitN ##1 !waitN ##1 waitN);

endmodule

// File: rtl/fpba_dpath.sv
module fpba_dpath
  import fpba_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuMreq,
  input  logic              cpuWr,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [ADDR_W-1:0] vidAddr,
  output logic [DATA_W-1:0] vidData,
  output logic              vidValid,
  output logic              vidSecond,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] vidAddrNext;
  logic [DATA_W-1:0] holdQ;

  assign vidAddrNext = vidAddr + ADDR_ONE;

  // Address multiplexer
  always_comb begin
    if (strb.cpuSel)     memAddr = cpuAddr;
    else if (strb.vidHi) memAddr = vidAddrNext;
    else                 memAddr = vidAddr;
  end

  // CPU write path, cut off from memory during the video phases
  assign memWe    = strb.cpuSel & cpuMreq & cpuWr;
  assign memWdata = strb.cpuSel ? cpuWdata : '0;

  // Read holding stage: transparent in G1, frozen otherwise
  always_ff @(posedge clk) begin
    if (rst)                 holdQ <= '0;
    else if (strb.latchOpen) holdQ <= memRdata;
  end

  assign cpuRdata = strb.latchOpen ? memRdata : holdQ;

  // Video byte capture
  always_ff @(posedge clk) begin
    if (rst) begin
      vidValid  <= 1'b0;
      vidSecond <= 1'b0;
      vidData   <= '0;
    end else begin
      vidValid  <= strb.vidRd;
      vidSecond <= strb.vidHi;
      if (strb.vidRd) vidData <= memRdata;
    end
  end

  // R5: no write strobe reaches memory while the video side owns the port
  assert_no_video_write_R5: assert property (@(posedge clk) disable iff (rst)
    strb.vidRd |-> !memWe);

  // R6: CPU read data is frozen across the closed phases
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!strb.latchOpen && !$past(strb.latchOpen)) |-> $stable(cpuRdata));

  // R7: the second-byte read is followed by a flagged valid strobe
  assert_vid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    strb.vidHi |=> (vidValid && vidSecond));

endmodule

// File: rtl/fourphase_bus_arbiter.sv
module fourphase_bus_arbiter
  import fpba_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuMreq,
  input  logic              cpuWr,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              waitN,
  input  logic [ADDR_W-1:0] vidAddr,
  output logic [DATA_W-1:0] vidData,
  output logic              vidValid,
  output logic              vidSecond,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata
);

  strobe_t strb;

  fpba_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .waitN (waitN)
  );

  fpba_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .cpuMreq   (cpuMreq),
    .cpuWr     (cpuWr),
    .cpuRdata  (cpuRdata),
    .vidAddr   (vidAddr),
    .vidData   (vidData),
    .vidValid  (vidValid),
    .vidSecond (vidSecond),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memWe     (memWe),
    .memRdata  (memRdata)
  );

  // R8: reset output state
  assert_reset_state_R8: assert property (@(posedge clk)
    $past(rst) |-> (waitN && !vidValid));

endmodule

// File: tb/fourphase_bus_arbiter_bench.sv
`timescale 1ns/100ps
module fourphase_bus_arbiter_bench;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NCYC = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuMreq = 1'b0;
  logic          cpuWr = 1'b0;
  logic [DW-1:0] cpuRdata;
  logic          waitN;
  logic [AW-1:0] vidAddr = '0;
  logic [DW-1:0] vidData;
  logic          vidValid;
  logic          vidSecond;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memWe;
  logic [DW-1:0] memRdata;

  logic [DW-1:0] mem [1<<AW];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fourphase_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_fourphase_bus_arbiter (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuMreq(cpuMreq), .cpuWr(cpuWr), .cpuRdata(cpuRdata), .waitN(waitN),
    .vidAddr(vidAddr), .vidData(vidData), .vidValid(vidValid),
    .vidSecond(vidSecond), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata)
  );

  // Memory model: combinational read, write committed at the edge
  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 7 + 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] grpVid;
    logic [DW-1:0] latchExp, vidExp0, vidExp1;
    bit mreq, wr;
    int ph;
    latchExp = '0; vidExp0 = '0; vidExp1 = '0; grpVid = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: state while reset is high
    chk(waitN == 1'b1, "R8 wait in reset", waitN, 1);
    chk(vidValid == 1'b0, "R8 video valid in reset", vidValid, 0);
    rst = 1'b0;

    for (int k = 0; k < NCYC; k++) begin
      if (k > 0) @(negedge clk);
      ph = k % 4;
      if (ph == 0) begin
        grpVid  = ((k / 4) == 3) ? AW'(255) : AW'((k / 4) * 53 + 250);
        vidAddr = grpVid;
      end
      cpuAddr  = AW'(k * 37 + 5);
      cpuWdata = DW'(k + 100);
      mreq     = (k % 3) != 0;
      wr       = (k % 5) < 3;
      cpuMreq  = mreq;
      cpuWr    = wr;
      #1;
      // R1/R2: release cadence
      chk(waitN == (ph == 0), "R1/R2 wait pattern", waitN, (ph == 0));
      // R3/R4: address multiplexer
      if (ph < 2)       chk(memAddr == cpuAddr, "R3 cpu address", memAddr, cpuAddr);
      else if (ph == 2) chk(memAddr == grpVid, "R4 video address", memAddr, grpVid);
      else              chk(memAddr == AW'(grpVid + 1), "R4 video address plus one", memAddr, AW'(grpVid + 1));
      // R5: write gating
      chk(memWe == (ph < 2 && mreq && wr), "R5 write enable", memWe, (ph < 2 && mreq && wr));
      if (ph < 2) chk(memWdata == cpuWdata, "R5 write data", memWdata, cpuWdata);
      else        chk(memWdata == '0, "R5 write data isolated", memWdata, 0);
      // R6: read holding stage
      if (ph == 0) begin
        latchExp = mem[cpuAddr];
        chk(cpuRdata == latchExp, "R6 transparent read", cpuRdata, latchExp);
      end else begin
        chk(cpuRdata == latchExp, "R6 held read", cpuRdata, latchExp);
      end
      // R7: video bytes
      if (ph == 2) vidExp0 = mem[grpVid];
      if (ph == 3) begin
        vidExp1 = mem[AW'(grpVid + 1)];
        chk(vidValid == 1'b1, "R7 first byte valid", vidValid, 1);
        chk(vidData == vidExp0, "R7 first byte data", vidData, vidExp0);
        chk(vidSecond == 1'b0, "R7 first byte flag", vidSecond, 0);
      end else if (ph == 0 && k > 0) begin
        chk(vidValid == 1'b1, "R7 second byte valid", vidValid, 1);
        chk(vidData == vidExp1, "R7 second byte data", vidData, vidExp1);
        chk(vidSecond == 1'b1, "R7 second byte flag", vidSecond, 1);
      end else begin
        chk(vidValid == 1'b0, "R7 idle valid", vidValid, 0);
      end
    end

    // R1/R8: synchronous reset in the middle of a group
    cpuMreq = 1'b0;
    cpuWr   = 1'b0;
    @(negedge clk); // G1
    @(negedge clk); // G2
    @(negedge clk); // G3
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(waitN == 1'b1, "R1 reset forces G1", waitN, 1);
    chk(vidValid == 1'b0, "R8 reset clears video valid", vidValid, 0);
    @(negedge clk);
    #1;
    chk(waitN == 1'b1, "R1 G1 held in reset", waitN, 1);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(waitN == 1'b0, "R1 advance to G2 after reset", waitN, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule